// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one warp-wide global memory instruction and turns it into a short list of memory segment requests. The instruction carries one byte address per lane, an active-lane mask, an access width in bytes and an atomic flag. The access width picks a segment size. Each active lane is mapped to the aligned segment that holds its address. Lanes of the same half-warp that fall into one segment share a single request, whose lane mask records every lane it serves.

Each request also records which quarters of its segment were touched. Before a request leaves the block, its size is cut in half wherever only one half of it is used. A 128-byte segment can shrink to 64 bytes and then to 32 bytes. A 64-byte segment can shrink to 32 bytes. The address moves up whenever the upper half is the part that is kept.

The block accepts one instruction at a time. It walks the lanes in order, one lane per cycle, and then emits the finished list one request per valid/ready handshake. A width it cannot map produces a one-cycle error pulse and no requests.

Top module: `mem_coalescer`

## Requirements
- R1: The untrimmed segment size is 32 bytes for width 1, 64 bytes for width 2, and 128 bytes for widths 4, 8 and 16. The segment address is the lane address with its low log2(size) bits cleared. Every emitted address is aligned to the emitted size, and every emitted size is 32, 64 or 128.
- R2: Within one half-warp, active lanes whose segment addresses match share one request. Bit i of `req_lanes_o` is set exactly when lane i is served by that request, so no request has an empty lane mask.
- R3: Lanes 0 to LANES/2-1 and lanes LANES/2 to LANES-1 never share a request, even when they address the same segment.
- R4: When `in_atomic_i` is 1, every active lane gets its own request with exactly one lane bit set.
- R5: Inactive lanes produce no requests. An instruction with an all-zero mask emits nothing and the block returns to ready.
- R6: Quarter q of a segment is (address / (size/4)) mod 4. A 128-byte request that uses only quarters {0,1} becomes 64 bytes at the segment address. One that uses only quarters {2,3} becomes 64 bytes at the segment address plus 64.
- R7: After a 128-to-64 cut, a request that uses only quarters from {0,2} becomes 32 bytes, and one that uses only quarters from {1,3} becomes 32 bytes with 32 added to its address. A 64-byte segment that uses only quarters {0,1} becomes 32 bytes at the segment address. One that uses only quarters {2,3} becomes 32 bytes at the segment address plus 32.
- R8: Requests leave in the order they were created. All first-half requests come first, and within each half the order follows the lowest lane of each request.
- R9: Any width other than 1, 2, 4, 8 or 16 raises `err_o` for one cycle, one clock after acceptance. Such an instruction emits no requests and leaves the block ready.
- R10: While `req_valid_o` is 1 and `req_ready_i` is 0, the valid signal, address, size and lane mask hold their values.
- R11: `in_ready_o` is 0 from the cycle after a legal instruction is accepted until its last request has completed a handshake.
- R12: After reset, `in_ready_o` is 1, and `req_valid_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Block idle and able to accept an instruction |
| in_addr_i | input | LANES*AW | Lane byte addresses; lane i at bits i*AW +: AW |
| in_mask_i | input | LANES | Active-lane mask |
| in_width_i | input | 5 | Access width in bytes |
| in_atomic_i | input | 1 | Atomic instruction; lanes do not merge |
| err_o | output | 1 | One-cycle pulse for an illegal width |
| req_valid_o | output | 1 | Request available |
| req_ready_i | input | 1 | Consumer takes the request |
| req_addr_o | output | AW | Trimmed request address |
| req_size_o | output | 8 | Request size in bytes (32, 64 or 128) |
| req_lanes_o | output | LANES | Lanes served by the request |

## Verification
The hardest situation to reach is a long, scattered request list in which merges, the half-warp boundary and both trimming steps all interact, with the consumer stalling part-way through. The stimulus gets there with lane addresses built from a base, a stride and an optional lane permutation. The permuted 64-byte stride puts two distant lanes of the second half into the same 128-byte segment. A stride of 128 fills all 32 list entries. A zero stride at an offset in the top quarter drives the two-step cut all the way down to 32 bytes. An independent list model in the bench predicts every request, and a gapped ready pattern holds requests under stall.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [1:0] {SEG32, SEG64, SEG128} seg_e;
  typedef enum logic [1:0] {ST_IDLE, ST_BUILD, ST_EMIT} coal_st_e;

  function automatic logic width_ok(input logic [4:0] w);
    return (w == 5'd1) || (w == 5'd2) || (w == 5'd4) || (w == 5'd8) || (w == 5'd16);
  endfunction

  function automatic seg_e width_seg(input logic [4:0] w);
    if (w == 5'd1) return SEG32;
    if (w == 5'd2) return SEG64;
    return SEG128;
  endfunction

endpackage

// File: rtl/coal_lane_map.sv
module coal_lane_map
  import coal_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  seg_e          sel_i,
  output logic [AW-1:0] seg_o,
  output logic [1:0]    quart_o
);
  always_comb begin
    case (sel_i)
      SEG32: begin
        seg_o   = {addr_i[AW-1:5], 5'b0};
        quart_o = addr_i[4:3];
      end
      SEG64: begin
        seg_o   = {addr_i[AW-1:6], 6'b0};
        quart_o = addr_i[5:4];
      end
      default: begin
        seg_o   = {addr_i[AW-1:7], 7'b0};
        quart_o = addr_i[6:5];
      end
    endcase
  end
endmodule

// File: rtl/coal_trim.sv
module coal_trim
  import coal_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] seg_i,
  input  seg_e          sel_i,
  input  logic [3:0]    used_i,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    size_o
);
  logic lo, hi, lo2, hi2;

  always_comb begin
    lo     = used_i[0] | used_i[1];
    hi     = used_i[2] | used_i[3];
    lo2    = used_i[0] | used_i[2];
    hi2    = used_i[1] | used_i[3];
    addr_o = seg_i;
    size_o = 8'd32;
    case (sel_i)
      SEG128: begin
        size_o = 8'd128;
        if (lo ^ hi) begin
          size_o = 8'd64;
          if (hi) addr_o = seg_i + AW'(64);
          // second pass pairs quarters by odd/even position
          if (lo2 ^ hi2) begin
            size_o = 8'd32;
            if (hi2) addr_o = addr_o + AW'(32);
          end
        end
      end
      SEG64: begin
        size_o = 8'd64;
        if (lo ^ hi) begin
          size_o = 8'd32;
          if (hi) addr_o = seg_i + AW'(32);
        end
      end
      default: size_o = 8'd32;
    endcase
  end
endmodule

// File: rtl/coal_req_table.sv
module coal_req_table #(
  parameter int AW    = 32,
  parameter int LANES = 32,
  parameter int DEPTH = LANES,
  localparam int IW   = $clog2(DEPTH + 1),
  localparam int LW   = $clog2(LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             half_end_i,
  input  logic             no_merge_i,
  input  logic [AW-1:0]    seg_i,
  input  logic [1:0]       quart_i,
  input  logic [LW-1:0]    lane_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [IW-1:0]    cnt_o,
  output logic [AW-1:0]    rd_seg_o,
  output logic [3:0]       rd_used_o,
  output logic [LANES-1:0] rd_lanes_o
);
  logic [AW-1:0]    seg_q   [DEPTH];
  logic [3:0]       used_q  [DEPTH];
  logic [LANES-1:0] lanes_q [DEPTH];
  logic [IW-1:0]    cnt_q, base_q, cnt_nxt;
  logic [DEPTH-1:0] hit;
  logic             append;

  // only entries of the current half-warp are merge candidates
  for (genvar k = 0; k < DEPTH; k++) begin : g_match
    assign hit[k] = !no_merge_i && (IW'(k) >= base_q) && (IW'(k) < cnt_q) &&
                    (seg_q[k] == seg_i);
  end

  assign append  = step_i && !(|hit) && (cnt_q < IW'(DEPTH));
  assign cnt_nxt = cnt_q + IW'(append);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      base_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (half_end_i) base_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (step_i && hit[k]) begin
        lanes_q[k][lane_i] <= 1'b1;
        used_q[k][quart_i] <= 1'b1;
      end
      if (append && (IW'(k) == cnt_q)) begin
        seg_q[k]   <= seg_i;
        used_q[k]  <= 4'b0001 << quart_i;
        lanes_q[k] <= LANES'(1) << lane_i;
      end
    end
  end

  always_comb begin
    rd_seg_o   = '0;
    rd_used_o  = '0;
    rd_lanes_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (IW'(k) == rd_idx_i) begin
        rd_seg_o   = seg_q[k];
        rd_used_o  = used_q[k];
        rd_lanes_o = lanes_q[k];
      end
    end
  end
endmodule

// File: rtl/mem_coalescer.sv
module mem_coalescer
  import coal_pkg::*;
#(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [LANES*AW-1:0] in_addr_i,
  input  logic [LANES-1:0]    in_mask_i,
  input  logic [4:0]          in_width_i,
  input  logic                in_atomic_i,
  output logic                err_o,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic [AW-1:0]       req_addr_o,
  output logic [7:0]          req_size_o,
  output logic [LANES-1:0]    req_lanes_o
);
  localparam int HALF = LANES / 2;
  localparam int LW   = $clog2(LANES);
  localparam int IW   = $clog2(LANES + 1);

  coal_st_e            st_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES-1:0]    mask_q;
  logic                atom_q;
  seg_e                sel_q;
  logic [LW-1:0]       lane_q;
  logic [IW-1:0]       emit_q;
  logic                err_q;

  logic                accept, legal, step, half_end, last_lane, hs;
  logic [AW-1:0]       cur_addr, cur_seg, rd_seg;
  logic [1:0]          cur_quart;
  logic [IW-1:0]       cnt;
  logic [3:0]          rd_used;

  assign in_ready_o = (st_q == ST_IDLE);
  assign accept     = in_valid_i && in_ready_o;
  assign legal      = width_ok(in_width_i);
  assign cur_addr   = addr_q[lane_q*AW +: AW];
  assign step       = (st_q == ST_BUILD) && mask_q[lane_q];
  assign half_end   = (st_q == ST_BUILD) && (lane_q == LW'(HALF - 1));
  assign last_lane  = (lane_q == LW'(LANES - 1));
  assign req_valid_o = (st_q == ST_EMIT) && (cnt != '0);
  assign hs         = req_valid_o && req_ready_i;
  assign err_o      = err_q;

  coal_lane_map #(.AW(AW)) u_map (
    .addr_i  (cur_addr),
    .sel_i   (sel_q),
    .seg_o   (cur_seg),
    .quart_o (cur_quart)
  );

  coal_req_table #(.AW(AW), .LANES(LANES), .DEPTH(LANES)) u_tab (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept && legal),
    .step_i     (step),
    .half_end_i (half_end),
    .no_merge_i (atom_q),
    .seg_i      (cur_seg),
    .quart_i    (cur_quart),
    .lane_i     (lane_q),
    .rd_idx_i   (emit_q),
    .cnt_o      (cnt),
    .rd_seg_o   (rd_seg),
    .rd_used_o  (rd_used),
    .rd_lanes_o (req_lanes_o)
  );

  coal_trim #(.AW(AW)) u_trim (
    .seg_i  (rd_seg),
    .sel_i  (sel_q),
    .used_i (rd_used),
    .addr_o (req_addr_o),
    .size_o (req_size_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      mask_q <= '0;
      atom_q <= 1'b0;
      sel_q  <= SEG32;
      lane_q <= '0;
      emit_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept && !legal;
      case (st_q)
        ST_IDLE: if (accept && legal) begin
          addr_q <= in_addr_i;
          mask_q <= in_mask_i;
          atom_q <= in_atomic_i;
          sel_q  <= width_seg(in_width_i);
          lane_q <= '0;
          st_q   <= ST_BUILD;
        end
        ST_BUILD: begin
          lane_q <= lane_q + LW'(1);
          if (last_lane) begin
            emit_q <= '0;
            st_q   <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (cnt == '0) st_q <= ST_IDLE;
          else if (hs) begin
            if (emit_q == cnt - IW'(1)) st_q <= ST_IDLE;
            else emit_q <= emit_q + IW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mem_coalescer_chk.sv
module mem_coalescer_chk #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             in_atomic_i,
  input logic             err_o,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic [AW-1:0]    req_addr_o,
  input logic [7:0]       req_size_o,
  input logic [LANES-1:0] req_lanes_o
);
  localparam int HALF = LANES / 2;

  logic atom_seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) atom_seen <= 1'b0;
    else if (in_valid_i && in_ready_o) atom_seen <= in_atomic_i;
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) &&
    $stable(req_size_o) && $stable(req_lanes_o));

  // R11
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !in_ready_o);

  // R1
  size_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_size_o == 8'd32 || req_size_o == 8'd64 || req_size_o == 8'd128) &&
    ((req_addr_o & (AW'(req_size_o) - AW'(1))) == '0));

  // R2
  lanes_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_lanes_o != '0);

  // R3
  half_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_lanes_o[HALF-1:0] == '0) || (req_lanes_o[LANES-1:HALF] == '0));

  // R4
  atomic_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && atom_seen |-> $countones(req_lanes_o) == 1);

  // R9
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !req_valid_o && in_ready_o);
endmodule

bind mem_coalescer mem_coalescer_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_atomic_i (in_atomic_i),
  .err_o       (err_o),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .req_size_o  (req_size_o),
  .req_lanes_o (req_lanes_o)
);

// File: tb/mem_coalescer_bench.sv
module mem_coalescer_bench;
  localparam int LANES = 32;
  localparam int AW    = 32;
  localparam int HALF  = LANES / 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [LANES*AW-1:0] in_addr = '0;
  logic [LANES-1:0]    in_mask = '0;
  logic [4:0]          in_width = 5'd4;
  logic                in_atomic = 1'b0;
  logic                err;
  logic                req_valid;
  logic                req_ready = 1'b1;
  logic [AW-1:0]       req_addr;
  logic [7:0]          req_size;
  logic [LANES-1:0]    req_lanes;

  always #5 clk = ~clk;

  mem_coalescer #(.LANES(LANES), .AW(AW)) u_mem_coalescer (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_addr_i(in_addr), .in_mask_i(in_mask), .in_width_i(in_width),
    .in_atomic_i(in_atomic), .err_o(err), .req_valid_o(req_valid),
    .req_ready_i(req_ready), .req_addr_o(req_addr), .req_size_o(req_size),
    .req_lanes_o(req_lanes)
  );

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  task automatic chk(input bit ok, input string req, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run hung (actual cycles %0d, expected < 150000)", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Stimulus table: lane address = base + idx*stride, idx = perm ? (lane*7)%LANES : lane
  typedef struct packed {
    logic [31:0] base;
    logic [31:0] stride;
    logic        perm;
    logic [31:0] mask;
    logic [4:0]  width;
    logic        atom;
    logic [7:0]  exp_n;
    logic        stall;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h1000, 32'd4,   1'b0, 32'hFFFF_FFFF, 5'd4,  1'b0, 8'd2,  1'b0}, // R1 R2 R6
    '{32'h2000, 32'd1,   1'b0, 32'hFFFF_FFFF, 5'd1,  1'b0, 8'd2,  1'b0}, // R3
    '{32'h3000, 32'd2,   1'b0, 32'hFFFF_FFFF, 5'd2,  1'b0, 8'd2,  1'b1}, // R7 R10
    '{32'h4000, 32'd8,   1'b0, 32'hFFFF_FFFF, 5'd8,  1'b0, 8'd2,  1'b0}, // R1 untrimmed
    '{32'h5000, 32'd128, 1'b0, 32'hFFFF_FFFF, 5'd4,  1'b0, 8'd32, 1'b1}, // R8 full list
    '{32'h6000, 32'd4,   1'b0, 32'h0000_00F0, 5'd4,  1'b1, 8'd4,  1'b0}, // R4
    '{32'h7000, 32'd64,  1'b1, 32'hFFFF_0001, 5'd16, 1'b0, 8'd14, 1'b1}, // R8 R2 scattered
    '{32'h9060, 32'd0,   1'b0, 32'hFFFF_FFFF, 5'd4,  1'b0, 8'd2,  1'b0}, // R6 R7 two-step
    '{32'hA000, 32'd4,   1'b0, 32'h0000_0000, 5'd4,  1'b0, 8'd0,  1'b0}, // R5
    '{32'hB005, 32'd0,   1'b0, 32'h0003_0003, 5'd1,  1'b1, 8'd4,  1'b0}  // R4 R5
  };

  // reference list
  logic [AW-1:0]    m_seg   [LANES];
  logic [3:0]       m_used  [LANES];
  logic [LANES-1:0] m_lanes [LANES];
  logic [AW-1:0]    m_addr  [LANES];
  logic [7:0]       m_size  [LANES];
  int               m_n;

  logic [AW-1:0]    g_addr  [LANES];
  logic [7:0]       g_size  [LANES];
  logic [LANES-1:0] g_lanes [LANES];
  int               g_n;

  task automatic model(input logic [LANES*AW-1:0] av, input logic [LANES-1:0] mk,
                       input logic [4:0] w, input logic at);
    int segsz;
    segsz = (w == 5'd1) ? 32 : (w == 5'd2) ? 64 : 128;
    m_n = 0;
    for (int h = 0; h < 2; h++) begin
      int start;
      start = m_n;
      for (int l = h * HALF; l < (h + 1) * HALF; l++) begin
        logic [AW-1:0] a, s;
        int q, f;
        if (!mk[l]) continue;
        a = av[l*AW +: AW];
        s = a & ~AW'(segsz - 1);
        q = int'((a / AW'(segsz / 4)) % 4);
        f = -1;
        if (!at) for (int j = start; j < m_n; j++) if (m_seg[j] == s) f = j;
        if (f >= 0) begin
          m_lanes[f][l] = 1'b1;
          m_used[f][q]  = 1'b1;
        end else begin
          m_seg[m_n]   = s;
          m_used[m_n]  = 4'b0001 << q;
          m_lanes[m_n] = LANES'(1) << l;
          m_n++;
        end
      end
    end
    for (int j = 0; j < m_n; j++) begin
      bit lo, hi;
      m_addr[j] = m_seg[j];
      m_size[j] = 8'(segsz);
      lo = m_used[j][0] | m_used[j][1];
      hi = m_used[j][2] | m_used[j][3];
      if (segsz == 128 && (lo ^ hi)) begin
        m_size[j] = 8'd64;
        if (hi) m_addr[j] += 64;
        lo = m_used[j][0] | m_used[j][2];
        hi = m_used[j][1] | m_used[j][3];
        if (lo ^ hi) begin
          m_size[j] = 8'd32;
          if (hi) m_addr[j] += 32;
        end
      end else if (segsz == 64 && (lo ^ hi)) begin
        m_size[j] = 8'd32;
        if (hi) m_addr[j] += 32;
      end
    end
  endtask

  task automatic run_case(input int id, input vec_t v);
    logic [LANES*AW-1:0] av;
    int k;
    for (int l = 0; l < LANES; l++) begin
      int idx;
      idx = v.perm ? (l * 7) % LANES : l;
      av[l*AW +: AW] = v.base + AW'(idx) * v.stride;
    end
    model(av, v.mask[LANES-1:0], v.width, v.atom);
    chk(m_n == int'(v.exp_n), "R2", $sformatf("vec %0d model count actual %0d expected %0d",
        id, m_n, v.exp_n));
    @(negedge clk);
    in_valid  = 1'b1;
    in_addr   = av;
    in_mask   = v.mask[LANES-1:0];
    in_width  = v.width;
    in_atomic = v.atom;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R11", $sformatf("vec %0d in_ready after accept actual %0b expected 0",
        id, in_ready));
    g_n = 0;
    k = 0;
    while (1) begin
      @(negedge clk);
      k++;
      req_ready = v.stall ? ((k % 3) != 0) : 1'b1;
      if (req_valid && req_ready && g_n < LANES) begin
        g_addr[g_n]  = req_addr;
        g_size[g_n]  = req_size;
        g_lanes[g_n] = req_lanes;
        g_n++;
      end
      if (in_ready || k > 3000) break;
    end
    req_ready = 1'b1;
    chk(g_n == m_n, "R5", $sformatf("vec %0d request count actual %0d expected %0d",
        id, g_n, m_n));
    for (int j = 0; j < g_n && j < m_n; j++) begin
      chk(g_addr[j] == m_addr[j] && g_size[j] == m_size[j], "R6/R7",
          $sformatf("vec %0d req %0d addr/size actual %h/%0d expected %h/%0d",
          id, j, g_addr[j], g_size[j], m_addr[j], m_size[j]));
      chk(g_lanes[j] == m_lanes[j], "R8",
          $sformatf("vec %0d req %0d lanes actual %h expected %h",
          id, j, g_lanes[j], m_lanes[j]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(in_ready == 1'b1 && req_valid == 1'b0 && err == 1'b0, "R12",
        $sformatf("reset ready/valid/err actual %0b%0b%0b expected 100", in_ready, req_valid, err));

    for (int i = 0; i < NV; i++) run_case(i, VECS[i]);

    // R9 illegal widths
    for (int w = 0; w < 2; w++) begin
      logic [4:0] bad;
      bit seen_valid, lost_ready;
      bad = (w == 0) ? 5'd3 : 5'd0;
      @(negedge clk);
      in_valid = 1'b1;
      in_width = bad;
      in_mask  = '1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(err == 1'b1, "R9", $sformatf("width %0d err pulse actual %0b expected 1", bad, err));
      @(negedge clk);
      chk(err == 1'b0, "R9", $sformatf("width %0d err after pulse actual %0b expected 0", bad, err));
      seen_valid = 1'b0;
      lost_ready = 1'b0;
      repeat (40) begin
        @(negedge clk);
        if (req_valid) seen_valid = 1'b1;
        if (!in_ready) lost_ready = 1'b1;
      end
      chk(!seen_valid && !lost_ready, "R9",
          $sformatf("width %0d valid/busy seen actual %0b%0b expected 00", bad, seen_valid, lost_ready));
    end

    // R10 directed hold under long stall
    begin
      vec_t v;
      logic [AW-1:0] a0;
      logic [7:0] s0;
      logic [LANES-1:0] l0;
      int k;
      v = VECS[0];
      req_ready = 1'b0;
      @(negedge clk);
      in_valid = 1'b1;
      for (int l = 0; l < LANES; l++) in_addr[l*AW +: AW] = v.base + AW'(l) * v.stride;
      in_mask = '1;
      in_width = 5'd4;
      in_atomic = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      k = 0;
      while (!req_valid && k < 200) begin
        @(negedge clk);
        k++;
      end
      a0 = req_addr; s0 = req_size; l0 = req_lanes;
      repeat (5) @(negedge clk);
      chk(req_valid && req_addr == a0 && req_size == s0 && req_lanes == l0, "R10",
          $sformatf("stalled req actual %0b %h/%0d expected 1 %h/%0d", req_valid, req_addr,
          req_size, a0, s0));
      chk(req_addr == 32'h1000 && req_size == 8'd64, "R6",
          $sformatf("first req actual %h/%0d expected 00001000/64", req_addr, req_size));
      req_ready = 1'b1;
      k = 0;
      while (!in_ready && k < 200) begin
        @(negedge clk);
        k++;
      end
      chk(in_ready == 1'b1, "R11", $sformatf("ready after drain actual %0b expected 1", in_ready));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule